// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block gathers up to 32 interrupt sources into one interrupt output line. Every source has two configuration bits. The first selects level or edge detection. The second selects the active sense: high or low for a level, rising or falling for an edge. Every raw input first passes through a two-flop synchroniser, and one further flop supplies the previous value for edge detection. A triggered source latches a bit in a pending register. Software acknowledges the bit by writing 1 to it. An enable mask decides which pending bits reach the output.

The output line has its own settings. One setting chooses a steady level or a one-cycle pulse. The other chooses active-high or active-low. A force register lets software raise any pending bit directly.

Software uses a simple single-cycle register bus. The address is a word index, so the byte offset is four times the index. All registers reset to zero. With that default, every source is level-sensitive and active-low, and the output is a level and active-low. The synchroniser flops reset to all ones, which is the idle value for this default configuration.

Top module: `trig_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 1, because a zero output polarity means active-low and nothing is pending. This holds while all sources are held high.
- R2: The word indices are: enable at 0, pending status at 1, source mode at 2, source polarity at 3, output mode at 4 (bit 0), output polarity at 5 (bit 0), and force at 6. The enable, mode and polarity registers read back what was written. Force always reads 0.
- R3: A source with mode bit 0 is level-triggered. Its pending bit sets when the synchronised input equals its polarity bit (1 = active-high, 0 = active-low). The bit is visible after the third rising clock edge that follows the input change, and not after the second.
- R4: A pending bit of a level-triggered source cannot be cleared while its level stays active. Once the level goes inactive, the bit stays set until it is written with 1.
- R5: A source with mode bit 1 is edge-triggered. Polarity 1 selects the rising edge and polarity 0 selects the falling edge. The opposite edge sets nothing. The pending bit stays set after the input returns to its old value.
- R6: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged. A new trigger in the same cycle wins over the clear.
- R7: Writing 1 to a force bit sets the matching pending bit on the next clock edge.
- R8: A pending bit whose enable bit is 0 has no effect on `irq_o`.
- R9: In output level mode (mode 0), the output is active while any pending bit is also enabled. Output polarity 1 drives the active state as 1, and polarity 0 drives it as 0.
- R10: In output pulse mode (mode 1), the output is active for exactly one cycle each time the set of enabled pending bits goes from empty to non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Raw interrupt sources, asynchronous |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW | Register word index |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt output line |

## Verification
The bench checks the exact synchroniser latency. A design with one flop too few or one too many would raise the pending bit a cycle early or a cycle late.

It tries to acknowledge a level source while the level is still active. A design that treated level sources as pure latches would lose that interrupt. It also checks that a level source that has gone inactive keeps its pending bit until it is acknowledged.

Edge sources are driven through the edge they do not select, and status is written with zeros. A design that got the sense wrong or cleared on any write would change the pending bits there.

In pulse mode the output must fall back after one cycle. A design that fed the level straight to the output would leave it high.

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o
);
  localparam logic [AW-1:0] A_ENA  = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_MODE = AW'(2);
  localparam logic [AW-1:0] A_POL  = AW'(3);
  localparam logic [AW-1:0] A_OMOD = AW'(4);
  localparam logic [AW-1:0] A_OPOL = AW'(5);
  localparam logic [AW-1:0] A_FRC  = AW'(6);

  logic [NSRC-1:0] enable_q, status_q, mode_q, pol_q;
  logic            omode_q, opol_q, any_q;
  logic [NSRC-1:0] sy1_q, sy2_q, sy3_q;

  wire [NSRC-1:0] wsrc = bus_wdata[NSRC-1:0];

  wire [NSRC-1:0] lvl_hit  = ~(sy2_q ^ pol_q);
  wire [NSRC-1:0] rise     = sy2_q & ~sy3_q;
  wire [NSRC-1:0] fall     = ~sy2_q & sy3_q;
  wire [NSRC-1:0] edge_hit = (pol_q & rise) | (~pol_q & fall);
  wire [NSRC-1:0] trig     = (mode_q & edge_hit) | (~mode_q & lvl_hit);

  wire [NSRC-1:0] clr = (bus_we && bus_addr == A_STAT) ? wsrc : '0;
  wire [NSRC-1:0] frc = (bus_we && bus_addr == A_FRC)  ? wsrc : '0;

  wire any = |(status_q & enable_q);
  wire act = omode_q ? (any & ~any_q) : any;
  assign irq_o = opol_q ? act : ~act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= '1;
      sy2_q <= '1;
      sy3_q <= '1;
    end else begin
      sy1_q <= src_i;
      sy2_q <= sy1_q;
      sy3_q <= sy2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      mode_q   <= '0;
      pol_q    <= '0;
      omode_q  <= 1'b0;
      opol_q   <= 1'b0;
    end else if (bus_we) begin
      if (bus_addr == A_ENA)  enable_q <= wsrc;
      if (bus_addr == A_MODE) mode_q   <= wsrc;
      if (bus_addr == A_POL)  pol_q    <= wsrc;
      if (bus_addr == A_OMOD) omode_q  <= bus_wdata[0];
      if (bus_addr == A_OPOL) opol_q   <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      any_q    <= 1'b0;
    end else begin
      status_q <= trig | frc | (status_q & ~clr);
      any_q    <= any;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ENA:   bus_rdata[NSRC-1:0] = enable_q;
      A_STAT:  bus_rdata[NSRC-1:0] = status_q;
      A_MODE:  bus_rdata[NSRC-1:0] = mode_q;
      A_POL:   bus_rdata[NSRC-1:0] = pol_q;
      A_OMOD:  bus_rdata[0]        = omode_q;
      A_OPOL:  bus_rdata[0]        = opol_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/trig_irq_ctrl_chk.sv
module trig_irq_ctrl_chk #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            irq_o,
  input logic [NSRC-1:0] status,
  input logic [NSRC-1:0] enable,
  input logic [NSRC-1:0] mode,
  input logic [NSRC-1:0] lvl_hit,
  input logic            omode,
  input logic            opol
);
  wire [NSRC-1:0] clrm = (bus_we && bus_addr == AW'(1)) ? bus_wdata[NSRC-1:0] : '0;
  wire            fwr  = bus_we && bus_addr == AW'(6);

  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lvl_hit) & ~$past(mode) & ~status) == '0)); // R4

  AST_NO_SILENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~status & ~$past(clrm)) == '0)); // R6

  AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fwr |=> ((status & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]))); // R7

  AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> (irq_o == !opol)); // R8

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (omode && irq_o == opol) |=> (!omode || opol != $past(opol) || irq_o != opol)); // R10
endmodule

bind trig_irq_ctrl trig_irq_ctrl_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_o(irq_o), .status(status_q), .enable(enable_q),
  .mode(mode_q), .lvl_hit(lvl_hit), .omode(omode_q), .opol(opol_q)
);

// File: tb/tb_trig_irq_ctrl.sv
module tb_trig_irq_ctrl;
  localparam int CLK_P = 10;
  localparam logic [2:0] ENA = 0, STAT = 1, MODE = 2, POL = 3, OMOD = 4, OPOL = 5, FRC = 6;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] src = '1;
  logic        we = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          runs = 0;
  int          fails = 0;

  trig_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R1 register zero after reset", v, 0);
    end
    chk("R1 irq_o idle high", {31'b0, irq}, 1);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(ENA, 32'h0000_00A5);
    wr(MODE, 32'h1234_0000);
    wr(POL, 32'h8000_0000);
    wr(OMOD, 32'h1);
    wr(OPOL, 32'h1);
    rd(ENA, v);  chk("R2 enable readback", v, 32'h0000_00A5);
    rd(MODE, v); chk("R2 mode readback", v, 32'h1234_0000);
    rd(POL, v);  chk("R2 polarity readback", v, 32'h8000_0000);
    rd(OMOD, v); chk("R2 output mode readback", v, 1);
    rd(OPOL, v); chk("R2 output polarity readback", v, 1);
    wr(FRC, 32'h0);
    rd(FRC, v);  chk("R2 force reads zero", v, 0);
    wr(ENA, 0); wr(MODE, 0); wr(POL, 0); wr(OMOD, 0); wr(OPOL, 0);
    wr(STAT, '1);
  endtask

  task automatic t_level();
    logic [31:0] v;
    @(negedge clk);
    src[2] = 0;
    wait_n(2);
    rd(STAT, v); chk("R3 not yet set after two edges", v, 0);
    wait_n(1);
    rd(STAT, v); chk("R3 active-low level sets on third edge", v, 32'h4);
    wr(STAT, 32'h4);
    rd(STAT, v); chk("R4 clear ignored while level active", v, 32'h4);
    src[2] = 1;
    wait_n(3);
    rd(STAT, v); chk("R4 stays pending after level drops", v, 32'h4);
    wr(STAT, 32'h4);
    rd(STAT, v); chk("R4 cleared once inactive", v, 0);
    src[5] = 0;
    wait_n(3);
    wr(POL, 32'h20);
    src[5] = 1;
    wait_n(3);
    rd(STAT, v); chk("R3 active-high level sets", v, 32'h20);
    wr(POL, 0);
    wr(STAT, '1);
    rd(STAT, v); chk("R3 cleared after restore", v, 0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(MODE, 32'h80);
    wr(POL, 32'h80);
    wr(STAT, '1);
    src[7] = 0;
    wait_n(3);
    rd(STAT, v); chk("R5 falling ignored for rising source", v, 0);
    src[7] = 1;
    wait_n(3);
    rd(STAT, v); chk("R5 rising edge sets", v, 32'h80);
    src[7] = 0;
    wait_n(3);
    rd(STAT, v); chk("R5 held after input returns", v, 32'h80);
    wr(STAT, 32'h0);
    rd(STAT, v); chk("R6 writing zero keeps bit", v, 32'h80);
    wr(STAT, 32'h80);
    rd(STAT, v); chk("R6 writing one clears", v, 0);
    wr(POL, 32'h0);
    src[7] = 1;
    wait_n(3);
    rd(STAT, v); chk("R5 rising ignored for falling source", v, 0);
    src[7] = 0;
    wait_n(3);
    rd(STAT, v); chk("R5 falling edge sets", v, 32'h80);
    src[7] = 1;
    wait_n(3);
    wr(MODE, 0);
    wr(STAT, '1);
    rd(STAT, v); chk("R6 all-ones clears", v, 0);
  endtask

  task automatic t_force();
    logic [31:0] v;
    wr(FRC, 32'h8000_0001);
    rd(STAT, v); chk("R7 force sets pending", v, 32'h8000_0001);
    wr(STAT, '1);
    rd(STAT, v); chk("R7 forced bits cleared", v, 0);
  endtask

  task automatic t_mask();
    wr(FRC, 32'h8);
    chk("R8 disabled pending has no effect", {31'b0, irq}, 1);
    wr(ENA, 32'h8);
    chk("R9 active-low level asserted", {31'b0, irq}, 0);
    wr(OPOL, 1);
    chk("R9 active-high level asserted", {31'b0, irq}, 1);
    wr(STAT, 32'h8);
    chk("R9 deasserted after ack", {31'b0, irq}, 0);
  endtask

  task automatic t_pulse();
    wr(OMOD, 1);
    chk("R10 idle before event", {31'b0, irq}, 0);
    wr(FRC, 32'h8);
    chk("R10 pulse asserted", {31'b0, irq}, 1);
    wait_n(1);
    chk("R10 pulse lasts one cycle", {31'b0, irq}, 0);
    wait_n(2);
    chk("R10 no repeat while pending", {31'b0, irq}, 0);
    wr(STAT, '1);
    wr(OMOD, 0); wr(OPOL, 0); wr(ENA, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(4);
    t_reset();
    t_regmap();
    t_level();
    t_edge();
    t_force();
    t_mask();
    t_pulse();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule